// File: doc/BRIEF.md
# I2C Byte Queue Threshold and Draining Logic

This block holds the transmit and receive byte queues that sit between an I2C controller's register port and its bus engine, and decides when software should be asked to refill or empty them. Software writes bytes for sending with a push strobe. The bus engine pulls them out one at a time as it shifts them onto the wire. In the receive direction the bus engine pushes incoming bytes, and software pops them through the register port.

A transfer begins with a start strobe. It carries a nonzero byte count and a direction flag. From then on the block counts down the bytes moved across the bus. It raises single-cycle events: a ready event when a whole threshold's worth of work is possible, and a draining event when the bytes left in the transfer are too few to ever reach the threshold. Because of the draining event, a short tail is serviced without waiting. Separate flush strobes empty either queue at once. A fixed code output reports the queue depth.

Top module: `i2c_fifo_events`

## Requirements
- R1: Each threshold equals its field value plus one, so it is always at least 1. The TX field is `thr_cfg[5:0]` and the RX field is `thr_cfg[13:8]`. Bits 15:14 and 7:6 have no effect.
- R2: During a receive transfer, `rx_rdy_evt` pulses in the cycle after the edge on which the RX level first becomes greater than or equal to the RX threshold.
- R3: During a receive transfer, `rx_drn_evt` pulses when all three of these become true: the remaining count is zero, the RX level is nonzero, and the RX level is below the RX threshold.
- R4: During a transmit transfer, `tx_rdy_evt` pulses when the TX level is below the TX threshold and the bytes not yet supplied are at least the threshold. The bytes not yet supplied are the remaining count minus the TX level, floored at zero.
- R5: During a transmit transfer, `tx_drn_evt` pulses when the TX level is below the TX threshold and the bytes not yet supplied are nonzero but fewer than the threshold.
- R6: Every event is a one-cycle pulse that marks entry into its condition. The ready and draining events of one direction never pulse together.
- R7: `flush_tx` and `flush_rx` each empty their queue on the edge where they are seen. A flush wins over a push or pop in the same cycle, and that push or pop is dropped.
- R8: `depth_code` equals the parameter n, and each queue holds exactly 8 << n bytes, which is 16 by default. Bytes leave in the order they entered. The head byte is visible on the read data output before it is popped.
- R9: A start strobe with a nonzero `xfer_len` loads the remaining count and latches the direction (`xfer_xmit` = 1 means transmit). A start strobe with a zero length is ignored completely.
- R10: The remaining count drops by one for each accepted bus-side byte: a TX pop from a non-empty queue, or an RX push into a non-full queue. It never drops below zero.
- R11: A push into a full TX queue, or a pop from an empty RX queue, is ignored and sets `err_sticky`. Only reset clears `err_sticky`. A bus-side pop from an empty TX queue, or a bus-side push into a full RX queue, is ignored and does not set the error.
- R12: After reset both queues are empty, the remaining count is zero, `err_sticky` is 0, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_cfg | input | 16 | Threshold fields: TX in [5:0], RX in [13:8], each holding threshold minus one |
| xfer_len | input | LEN_W | Byte count loaded at start |
| xfer_start | input | 1 | Start strobe for a new transfer |
| xfer_xmit | input | 1 | Direction at start: 1 = transmit, 0 = receive |
| flush_tx | input | 1 | Empties the TX queue |
| flush_rx | input | 1 | Empties the RX queue |
| tx_push | input | 1 | Register-port write into the TX queue |
| tx_wdata | input | 8 | Byte written into the TX queue |
| tx_pop | input | 1 | Bus engine takes the TX head byte |
| tx_rdata | output | 8 | TX head byte |
| rx_push | input | 1 | Bus engine delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Register-port read of the RX head byte |
| rx_rdata | output | 8 | RX head byte |
| tx_rdy_evt | output | 1 | Transmit-ready pulse |
| tx_drn_evt | output | 1 | Transmit-draining pulse |
| rx_rdy_evt | output | 1 | Receive-ready pulse |
| rx_drn_evt | output | 1 | Receive-draining pulse |
| depth_code | output | 3 | Queue depth code n, where depth is 8 << n |
| err_sticky | output | 1 | Sticky flag for an overfilled TX queue or an over-read RX queue |

## Verification
The main event rules are tried with four input patterns:
- A five-byte transmit transfer. Software fills the queue up to the threshold, then the bus drains it. This separates the ready pulse from the draining pulse that appears once only two bytes remain unsupplied.
- A four-byte receive transfer. This shows the ready pulse at the threshold level and the draining pulse when the last byte arrives with only two bytes queued.
- An unequal threshold configuration with stray high bits set. This confirms that the two fields are decoded from their own positions and ignore the stray bits.
- Extra receive bytes beyond the transfer length. Because the draining pulse returns only if the count stays at zero rather than wrapping, this exposes any underflow.

Directed cases cover queue capacity and byte order, flush priority over a push in the same cycle, and a zero-length start that must leave a pending count untouched.

// File: rtl/i2c_fifo_events.sv
module i2c_fifo_events #(
  parameter int DEPTH_CODE = 1,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      thr_cfg,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_start,
  input  logic             xfer_xmit,
  input  logic             flush_tx,
  input  logic             flush_rx,
  input  logic             tx_push,
  input  logic [7:0]       tx_wdata,
  input  logic             tx_pop,
  output logic [7:0]       tx_rdata,
  input  logic             rx_push,
  input  logic [7:0]       rx_wdata,
  input  logic             rx_pop,
  output logic [7:0]       rx_rdata,
  output logic             tx_rdy_evt,
  output logic             tx_drn_evt,
  output logic             rx_rdy_evt,
  output logic             rx_drn_evt,
  output logic [2:0]       depth_code,
  output logic             err_sticky
);
  localparam int DEPTH = 8 << DEPTH_CODE;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = AW + 1;

  logic [7:0]       tx_mem [DEPTH];
  logic [7:0]       rx_mem [DEPTH];
  logic [AW-1:0]    tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic [LEN_W-1:0] remain;
  logic             dir_tx;
  logic [3:0]       cond, cond_q;

  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_we, tx_re, rx_we, rx_re;
  logic [LEN_W-1:0] tx_thr, rx_thr, tx_lx, rx_lx, need;
  logic cfg_unused;

  assign cfg_unused = ^{thr_cfg[15:14], thr_cfg[7:6]};

  assign tx_full  = (tx_lvl == LW'(DEPTH));
  assign tx_empty = (tx_lvl == '0);
  assign rx_full  = (rx_lvl == LW'(DEPTH));
  assign rx_empty = (rx_lvl == '0);

  assign tx_we = tx_push & ~tx_full  & ~flush_tx;
  assign tx_re = tx_pop  & ~tx_empty & ~flush_tx;
  assign rx_we = rx_push & ~rx_full  & ~flush_rx;
  assign rx_re = rx_pop  & ~rx_empty & ~flush_rx;

  assign tx_thr = LEN_W'(thr_cfg[5:0])  + LEN_W'(1);
  assign rx_thr = LEN_W'(thr_cfg[13:8]) + LEN_W'(1);
  assign tx_lx  = LEN_W'(tx_lvl);
  assign rx_lx  = LEN_W'(rx_lvl);
  assign need   = (remain > tx_lx) ? remain - tx_lx : '0;

  assign cond[3] = dir_tx  & (tx_lx < tx_thr) & (need >= tx_thr);
  assign cond[2] = dir_tx  & (tx_lx < tx_thr) & (need != '0) & (need < tx_thr);
  assign cond[1] = ~dir_tx & (rx_lx >= rx_thr);
  assign cond[0] = ~dir_tx & (remain == '0) & (rx_lx != '0) & (rx_lx < rx_thr);

  assign {tx_rdy_evt, tx_drn_evt, rx_rdy_evt, rx_drn_evt} = cond & ~cond_q;

  assign tx_rdata   = tx_mem[tx_rp];
  assign rx_rdata   = rx_mem[rx_rp];
  assign depth_code = 3'(DEPTH_CODE);

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_wp] <= tx_wdata;
    if (rx_we) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
      remain <= '0; dir_tx <= 1'b0; cond_q <= '0; err_sticky <= 1'b0;
    end else begin
      cond_q <= cond;
      err_sticky <= err_sticky | (tx_push & tx_full & ~flush_tx)
                                | (rx_pop & rx_empty & ~flush_rx);
      if (flush_tx) begin
        tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      end else begin
        if (tx_we) tx_wp <= tx_wp + AW'(1);
        if (tx_re) tx_rp <= tx_rp + AW'(1);
        tx_lvl <= tx_lvl + LW'(tx_we) - LW'(tx_re);
      end
      if (flush_rx) begin
        rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
      end else begin
        if (rx_we) rx_wp <= rx_wp + AW'(1);
        if (rx_re) rx_rp <= rx_rp + AW'(1);
        rx_lvl <= rx_lvl + LW'(rx_we) - LW'(rx_re);
      end
      if (xfer_start && xfer_len != '0) begin
        remain <= xfer_len;
        dir_tx <= xfer_xmit;
      end else if ((tx_re || rx_we) && remain != '0) begin
        remain <= remain - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_fifo_events_chk.sv
module i2c_fifo_events_chk #(
  parameter int LEN_W = 16,
  parameter int LW    = 5,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] xfer_len,
  input logic             xfer_start,
  input logic             flush_tx,
  input logic             flush_rx,
  input logic             tx_push,
  input logic             tx_pop,
  input logic [LW-1:0]    tx_lvl,
  input logic [LW-1:0]    rx_lvl,
  input logic [LEN_W-1:0] remain,
  input logic             tx_rdy_evt,
  input logic             tx_drn_evt,
  input logic             rx_rdy_evt,
  input logic             rx_drn_evt,
  input logic             err_sticky
);
  // R6
  excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_rdy_evt && tx_drn_evt) && !(rx_rdy_evt && rx_drn_evt));
  // R6
  tx_rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy_evt |=> !tx_rdy_evt);
  // R6
  rx_drn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drn_evt |=> !rx_drn_evt);
  // R3
  rx_drn_remain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drn_evt |-> remain == '0);
  // R7
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx |=> rx_lvl == '0);
  // R7
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx |=> tx_lvl == '0);
  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && xfer_len != '0) |=> remain == $past(xfer_len));
  // R10
  no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |=> remain <= $past(remain));
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_pop && !flush_tx && tx_lvl == LW'(DEPTH)) |=>
      (tx_lvl == LW'(DEPTH) && err_sticky));
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

bind i2c_fifo_events i2c_fifo_events_chk #(.LEN_W(LEN_W), .LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_len(xfer_len), .xfer_start(xfer_start),
  .flush_tx(flush_tx), .flush_rx(flush_rx), .tx_push(tx_push), .tx_pop(tx_pop),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .remain(remain),
  .tx_rdy_evt(tx_rdy_evt), .tx_drn_evt(tx_drn_evt),
  .rx_rdy_evt(rx_rdy_evt), .rx_drn_evt(rx_drn_evt), .err_sticky(err_sticky));

// File: tb/i2c_fifo_events_tb.sv
module i2c_fifo_events_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] thr_cfg = 16'h0202;
  logic [15:0] xfer_len = '0;
  logic xfer_start = 0, xfer_xmit = 0, flush_tx = 0, flush_rx = 0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic [7:0] tx_rdata, rx_rdata;
  logic tx_rdy_evt, tx_drn_evt, rx_rdy_evt, rx_drn_evt, err_sticky;
  logic [2:0] depth_code;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] s_evt;
  logic s_err;
  logic [7:0] s_txd_pre, s_rxd_pre;

  always #10 clk = ~clk;

  i2c_fifo_events u_dut (.*);

  // {len[3:0], ctrl[7:0] = start,xmit,ftx,frx,tpush,tpop,rpush,rpop, data, evt {txr,txd,rxr,rxd}, err}
  localparam logic [24:0] VEC [22] = '{
    {4'd5, 8'hC0, 8'h00, 4'b1000, 1'b0},
    {4'd0, 8'h08, 8'h11, 4'b0000, 1'b0},
    {4'd0, 8'h08, 8'h22, 4'b0000, 1'b0},
    {4'd0, 8'h08, 8'h33, 4'b0000, 1'b0},
    {4'd0, 8'h04, 8'h00, 4'b0100, 1'b0},
    {4'd0, 8'h08, 8'h44, 4'b0000, 1'b0},
    {4'd0, 8'h08, 8'h55, 4'b0000, 1'b0},
    {4'd0, 8'h04, 8'h00, 4'b0000, 1'b0},
    {4'd0, 8'h04, 8'h00, 4'b0000, 1'b0},
    {4'd0, 8'h04, 8'h00, 4'b0000, 1'b0},
    {4'd0, 8'h04, 8'h00, 4'b0000, 1'b0},
    {4'd0, 8'h04, 8'h00, 4'b0000, 1'b0},
    {4'd0, 8'h01, 8'h00, 4'b0000, 1'b1},
    {4'd4, 8'h80, 8'h00, 4'b0000, 1'b1},
    {4'd0, 8'h02, 8'hA1, 4'b0000, 1'b1},
    {4'd0, 8'h02, 8'hA2, 4'b0000, 1'b1},
    {4'd0, 8'h02, 8'hA3, 4'b0010, 1'b1},
    {4'd0, 8'h01, 8'h00, 4'b0000, 1'b1},
    {4'd0, 8'h01, 8'h00, 4'b0000, 1'b1},
    {4'd0, 8'h02, 8'hA4, 4'b0001, 1'b1},
    {4'd0, 8'h01, 8'h00, 4'b0000, 1'b1},
    {4'd0, 8'h01, 8'h00, 4'b0000, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] len, input logic [7:0] ctrl, input logic [7:0] d);
    @(negedge clk);
    s_txd_pre = tx_rdata;
    s_rxd_pre = rx_rdata;
    xfer_len = len;
    {xfer_start, xfer_xmit, flush_tx, flush_rx, tx_push, tx_pop, rx_push, rx_pop} = ctrl;
    tx_wdata = d;
    rx_wdata = d;
    @(posedge clk);
    #5;
    s_evt = {tx_rdy_evt, tx_drn_evt, rx_rdy_evt, rx_drn_evt};
    s_err = err_sticky;
    {xfer_start, xfer_xmit, flush_tx, flush_rx, tx_push, tx_pop, rx_push, rx_pop} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(16'd0, 8'h00, 8'h00);
    chk("R12 events after reset", 16'(s_evt), 16'h0);
    chk("R12 err after reset", 16'(s_err), 16'h0);
    chk("R8 depth code", 16'(depth_code), 16'h1);

    // R2 R3 R4 R5 R11 table walk
    for (int i = 0; i < 22; i++) begin
      cyc(16'(VEC[i][24:21]), VEC[i][20:13], VEC[i][12:5]);
      chk($sformatf("R2/R3/R4/R5 events step %0d", i), 16'(s_evt), 16'(VEC[i][4:1]));
      chk($sformatf("R11 err step %0d", i), 16'(s_err), 16'(VEC[i][0]));
    end

    // R12 err cleared only by reset
    do_reset();
    cyc(16'd0, 8'h00, 8'h00);
    chk("R12 err cleared by reset", 16'(s_err), 16'h0);

    // R8 capacity and order, R11 overfill
    cyc(16'd40, 8'hC0, 8'h00);
    for (int i = 0; i < 16; i++) cyc(16'd0, 8'h08, 8'(8'h40 + i));
    chk("R8 sixteen pushes no error", 16'(s_err), 16'h0);
    cyc(16'd0, 8'h08, 8'hEE);
    chk("R11 push into full sets err", 16'(s_err), 16'h1);
    for (int i = 0; i < 16; i++) begin
      cyc(16'd0, 8'h04, 8'h00);
      chk($sformatf("R8 order byte %0d", i), 16'(s_txd_pre), 16'(8'h40 + i));
    end

    // R1 field positions, R2 at threshold 5
    do_reset();
    thr_cfg = 16'hC4C0;
    cyc(16'd8, 8'h80, 8'h00);
    for (int i = 0; i < 4; i++) begin
      cyc(16'd0, 8'h02, 8'(i));
      chk("R1 rx below threshold 5", 16'(s_evt), 16'h0);
    end
    cyc(16'd0, 8'h02, 8'h09);
    chk("R1 R2 rx ready at level 5", 16'(s_evt), 16'b0010);
    cyc(16'd3, 8'hC0, 8'h00);
    chk("R1 R4 tx threshold 1 ready", 16'(s_evt), 16'b1000);

    // R7 flush wins over push
    do_reset();
    thr_cfg = 16'h0202;
    cyc(16'd8, 8'h80, 8'h00);
    cyc(16'd0, 8'h02, 8'hAA);
    cyc(16'd0, 8'h02, 8'hBB);
    cyc(16'd0, 8'h12, 8'hCC);
    cyc(16'd0, 8'h02, 8'hDD);
    cyc(16'd0, 8'h01, 8'h00);
    chk("R7 rx head after flush", 16'(s_rxd_pre), 16'h00DD);
    chk("R7 rx pop after flush no err", 16'(s_err), 16'h0);
    cyc(16'd8, 8'hC0, 8'h00);
    cyc(16'd0, 8'h08, 8'h11);
    cyc(16'd0, 8'h28, 8'h22);
    cyc(16'd0, 8'h08, 8'h33);
    cyc(16'd0, 8'h04, 8'h00);
    chk("R7 tx head after flush", 16'(s_txd_pre), 16'h0033);

    // R9 zero-length start ignored
    do_reset();
    cyc(16'd2, 8'h80, 8'h00);
    cyc(16'd0, 8'h02, 8'h01);
    chk("R9 one byte pending", 16'(s_evt), 16'h0);
    cyc(16'd0, 8'h80, 8'h00);
    chk("R9 zero-length start ignored", 16'(s_evt), 16'h0);
    cyc(16'd0, 8'h02, 8'h02);
    chk("R3 R9 drain on last byte", 16'(s_evt), 16'b0001);

    // R10 no underflow
    do_reset();
    cyc(16'd1, 8'h80, 8'h00);
    cyc(16'd0, 8'h02, 8'h05);
    chk("R10 drain after single byte", 16'(s_evt), 16'b0001);
    cyc(16'd0, 8'h02, 8'h06);
    chk("R6 R10 no repeat pulse", 16'(s_evt), 16'h0);
    cyc(16'd0, 8'h01, 8'h00);
    cyc(16'd0, 8'h01, 8'h00);
    chk("R10 empty no event", 16'(s_evt), 16'h0);
    cyc(16'd0, 8'h02, 8'h07);
    chk("R10 count held at zero", 16'(s_evt), 16'b0001);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule